// File: doc/BRIEF.md
# Dual-Round SHA-256 Compression Core

This block applies the SHA-256 compression function to one 512-bit message block. It finishes two rounds in every clock cycle, so the full 64-round loop takes 32 cycles. A one-cycle finish step then adds the working variables back onto the chaining value. The caller supplies the eight 32-bit chaining words with a start pulse. It also supplies the message words already combined with the round constants (W+K). These arrive as one pair per cycle, low word for the even round and high word for the odd round. The core never adds W and K itself. Padding and the message schedule are left to the logic that feeds it.

Inside the loop, each cycle already computes the sums that the next round pair needs: h plus its W+K word, and d plus h plus W+K. These sums come only from words that shift through unchanged. They are held in registers, so each new a and e needs only its sigma/choose/majority terms folded in. Every three-operand sum goes through a 3:2 carry-save stage and a single carry-propagate adder. A parameter can swap this for plain adders.

Top module: `sha2x_core`

## Requirements
- R1: While idle, a high `start` loads `chain_in` as the working and chaining state. Word A sits at bits 255:224 and word H at bits 31:0. The same edge takes the first W+K pair, and `busy` is high from the next cycle on.
- R2: `wk_take` is high exactly in the cycles where the core samples `wk_lo` and `wk_hi`. These are the start cycle and the first 31 round cycles. The k-th sampled pair carries round 2k on `wk_lo` and round 2k+1 on `wk_hi`, for 32 pairs per block.
- R3: Two rounds complete per cycle. `busy` stays high for exactly 33 cycles after the start edge: 32 round cycles and one finish cycle.
- R4: `digest` equals the SHA-256 compression of the block: each final working word is added modulo 2^32 to its starting chaining word, in the same word order as `chain_in`. With the standard initial hash, the single-block "abc" and empty messages give their published digests.
- R5: `done` is a one-cycle pulse in the cycle after `busy` falls. `digest` changes only with that pulse and holds its value until the next one.
- R6: `start` has no effect while `busy` is high. The running block's result and the `wk_take` timing are unchanged.
- R7: After reset, `busy`, `done` and `digest` are zero, and `wk_take` is low while `start` is low.
- R8: Any chaining value works as the start state, so multi-block messages can be chained through `chain_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one block; taken only while idle |
| chain_in | input | 256 | Starting chaining value, word A in the top 32 bits |
| wk_lo | input | 32 | Pre-added W+K for the even round of the pair |
| wk_hi | input | 32 | Pre-added W+K for the odd round of the pair |
| wk_take | output | 1 | The core samples wk_lo/wk_hi at the next edge |
| busy | output | 1 | A block is in progress |
| done | output | 1 | One-cycle pulse: digest is new |
| digest | output | 256 | Compression result, same word order as chain_in |

## Verification
The assertions assume that the source puts the correct W+K pair on `wk_lo`/`wk_hi` in every cycle where `wk_take` is high, and that `chain_in` is valid in the cycle `start` is taken. They also assume that reset is applied before the first start. The bench builds its own message schedule from the round-constant table. It presents pair k+1 in the cycle after pair k was taken and drives arbitrary values only once `wk_take` is low. It raises `start` only while idle, except for one deliberate pulse in the middle of a run.

// File: rtl/sha2x_pkg.sv
`timescale 1ns/1ps
package sha2x_pkg;
   localparam int unsigned WORD_W = 32;
   localparam int unsigned NVARS  = 8;

   typedef logic [WORD_W-1:0] word_t;

   typedef struct packed {
      word_t a;
      word_t b;
      word_t c;
      word_t d;
      word_t e;
      word_t f;
      word_t g;
      word_t h;
   } work_t;

   typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} phase_t;

   function automatic word_t rotr(input word_t x, input int unsigned n);
      return (x >> n) | (x << (WORD_W - n));
   endfunction

   function automatic word_t big_s0(input word_t x);
      return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
   endfunction

   function automatic word_t big_s1(input word_t x);
      return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
   endfunction

   function automatic word_t choose_f(input word_t x, input word_t y, input word_t z);
      return (x & y) ^ (~x & z);
   endfunction

   function automatic word_t major_f(input word_t x, input word_t y, input word_t z);
      return (x & y) ^ (x & z) ^ (y & z);
   endfunction
endpackage

// File: rtl/sha2x_add3.sv
`timescale 1ns/1ps
module sha2x_add3 #(
   parameter int unsigned W       = 32,
   parameter bit          USE_CSA = 1'b1
) (
   input  logic [W-1:0] x_i,
   input  logic [W-1:0] y_i,
   input  logic [W-1:0] z_i,
   output logic [W-1:0] s_o
);
   if (W < 2) begin : g_bad_w
      $error("sha2x_add3: W must be at least 2");
   end

   if (USE_CSA) begin : g_csa
      logic [W-1:0] part_sum;
      logic [W-1:0] part_cry;
      assign part_sum = x_i ^ y_i ^ z_i;
      assign part_cry = (x_i & y_i) | (x_i & z_i) | (y_i & z_i);
      assign s_o      = part_sum + {part_cry[W-2:0], 1'b0};
   end else begin : g_plain
      assign s_o = x_i + y_i + z_i;
   end
endmodule

// File: rtl/sha2x_precomp.sv
`timescale 1ns/1ps
module sha2x_precomp import sha2x_pkg::*; #(
   parameter bit USE_CSA = 1'b1
) (
   input  word_t h_src_i,
   input  word_t g_src_i,
   input  word_t d_src_i,
   input  word_t c_src_i,
   input  word_t wk_lo_i,
   input  word_t wk_hi_i,
   output word_t pre_h0_o,
   output word_t pre_dh0_o,
   output word_t pre_h1_o,
   output word_t pre_cg1_o
);
   assign pre_h0_o = h_src_i + wk_lo_i;
   assign pre_h1_o = g_src_i + wk_hi_i;

   sha2x_add3 #(.W(WORD_W), .USE_CSA(USE_CSA)) u_dh0 (
      .x_i(d_src_i), .y_i(h_src_i), .z_i(wk_lo_i), .s_o(pre_dh0_o));

   sha2x_add3 #(.W(WORD_W), .USE_CSA(USE_CSA)) u_cg1 (
      .x_i(c_src_i), .y_i(g_src_i), .z_i(wk_hi_i), .s_o(pre_cg1_o));
endmodule

// File: rtl/sha2x_round_pair.sv
`timescale 1ns/1ps
module sha2x_round_pair import sha2x_pkg::*; #(
   parameter bit USE_CSA = 1'b1
) (
   input  word_t a_i,
   input  word_t b_i,
   input  word_t c_i,
   input  word_t e_i,
   input  word_t f_i,
   input  word_t g_i,
   input  word_t pre_h0_i,
   input  word_t pre_dh0_i,
   input  word_t pre_h1_i,
   input  word_t pre_cg1_i,
   output word_t a1_o,
   output word_t e1_o,
   output word_t a2_o,
   output word_t e2_o
);
   word_t s1_0, ch_0, s0_0, mj_0, t1_0;
   word_t s1_1, ch_1, s0_1, mj_1, t1_1;

   // even round
   assign s1_0 = big_s1(e_i);
   assign ch_0 = choose_f(e_i, f_i, g_i);
   assign s0_0 = big_s0(a_i);
   assign mj_0 = major_f(a_i, b_i, c_i);

   sha2x_add3 #(.W(WORD_W), .USE_CSA(USE_CSA)) u_t1_0 (
      .x_i(pre_h0_i), .y_i(s1_0), .z_i(ch_0), .s_o(t1_0));
   sha2x_add3 #(.W(WORD_W), .USE_CSA(USE_CSA)) u_e_0 (
      .x_i(pre_dh0_i), .y_i(s1_0), .z_i(ch_0), .s_o(e1_o));
   sha2x_add3 #(.W(WORD_W), .USE_CSA(USE_CSA)) u_a_0 (
      .x_i(t1_0), .y_i(s0_0), .z_i(mj_0), .s_o(a1_o));

   // odd round: previous h is old g, previous d is old c
   assign s1_1 = big_s1(e1_o);
   assign ch_1 = choose_f(e1_o, e_i, f_i);
   assign s0_1 = big_s0(a1_o);
   assign mj_1 = major_f(a1_o, a_i, b_i);

   sha2x_add3 #(.W(WORD_W), .USE_CSA(USE_CSA)) u_t1_1 (
      .x_i(pre_h1_i), .y_i(s1_1), .z_i(ch_1), .s_o(t1_1));
   sha2x_add3 #(.W(WORD_W), .USE_CSA(USE_CSA)) u_e_1 (
      .x_i(pre_cg1_i), .y_i(s1_1), .z_i(ch_1), .s_o(e2_o));
   sha2x_add3 #(.W(WORD_W), .USE_CSA(USE_CSA)) u_a_1 (
      .x_i(t1_1), .y_i(s0_1), .z_i(mj_1), .s_o(a2_o));
endmodule

// File: rtl/sha2x_core.sv
`timescale 1ns/1ps
module sha2x_core import sha2x_pkg::*; #(
   parameter int unsigned ROUNDS  = 64,
   parameter bit          USE_CSA = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic [NVARS*WORD_W-1:0]  chain_in,
   input  logic [WORD_W-1:0]        wk_lo,
   input  logic [WORD_W-1:0]        wk_hi,
   output logic                     wk_take,
   output logic                     busy,
   output logic                     done,
   output logic [NVARS*WORD_W-1:0]  digest
);
   localparam int unsigned PAIRS = ROUNDS / 2;
   localparam int unsigned CNT_W = $clog2(PAIRS);
   localparam int unsigned MON_W = CNT_W + 2;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(PAIRS - 1);

   if (ROUNDS < 4 || (ROUNDS % 2) != 0) begin : g_bad_rounds
      $error("sha2x_core: ROUNDS must be even and at least 4");
   end

   phase_t                    phase_q;
   logic [CNT_W-1:0]          cnt_q;
   work_t                     work_q;
   work_t                     load_w;
   logic [NVARS*WORD_W-1:0]   chain_q;
   logic [NVARS*WORD_W-1:0]   digest_q;
   logic [NVARS*WORD_W-1:0]   ff_sum;
   logic                      done_q;
   logic                      accept;
   word_t pre_h0_q, pre_dh0_q, pre_h1_q, pre_cg1_q;
   word_t pre_h0_n, pre_dh0_n, pre_h1_n, pre_cg1_n;
   word_t src_h, src_g, src_d, src_c;
   word_t rp_a1, rp_e1, rp_a2, rp_e2;

   assign load_w  = work_t'(chain_in);
   assign accept  = (phase_q == ST_IDLE) && start;
   assign wk_take = accept || ((phase_q == ST_RUN) && (cnt_q != LAST));
   assign busy    = (phase_q != ST_IDLE);
   assign done    = done_q;
   assign digest  = digest_q;

   // words that become h, g, d, c of the next round pair
   always_comb begin
      if (phase_q == ST_IDLE) begin
         src_h = load_w.h;
         src_g = load_w.g;
         src_d = load_w.d;
         src_c = load_w.c;
      end else begin
         src_h = work_q.f;
         src_g = work_q.e;
         src_d = work_q.b;
         src_c = work_q.a;
      end
   end

   sha2x_precomp #(.USE_CSA(USE_CSA)) u_pre (
      .h_src_i(src_h), .g_src_i(src_g), .d_src_i(src_d), .c_src_i(src_c),
      .wk_lo_i(wk_lo), .wk_hi_i(wk_hi),
      .pre_h0_o(pre_h0_n), .pre_dh0_o(pre_dh0_n),
      .pre_h1_o(pre_h1_n), .pre_cg1_o(pre_cg1_n));

   sha2x_round_pair #(.USE_CSA(USE_CSA)) u_pair (
      .a_i(work_q.a), .b_i(work_q.b), .c_i(work_q.c),
      .e_i(work_q.e), .f_i(work_q.f), .g_i(work_q.g),
      .pre_h0_i(pre_h0_q), .pre_dh0_i(pre_dh0_q),
      .pre_h1_i(pre_h1_q), .pre_cg1_i(pre_cg1_q),
      .a1_o(rp_a1), .e1_o(rp_e1), .a2_o(rp_a2), .e2_o(rp_e2));

   for (genvar i = 0; i < NVARS; i++) begin : g_ffwd
      assign ff_sum[WORD_W*i +: WORD_W] =
         chain_q[WORD_W*i +: WORD_W] + work_q[WORD_W*i +: WORD_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= ST_IDLE;
         cnt_q     <= '0;
         work_q    <= '0;
         chain_q   <= '0;
         digest_q  <= '0;
         done_q    <= 1'b0;
         pre_h0_q  <= '0;
         pre_dh0_q <= '0;
         pre_h1_q  <= '0;
         pre_cg1_q <= '0;
      end else begin
         done_q <= 1'b0;
         case (phase_q)
            ST_IDLE: if (start) begin
               work_q    <= load_w;
               chain_q   <= chain_in;
               cnt_q     <= '0;
               pre_h0_q  <= pre_h0_n;
               pre_dh0_q <= pre_dh0_n;
               pre_h1_q  <= pre_h1_n;
               pre_cg1_q <= pre_cg1_n;
               phase_q   <= ST_RUN;
            end
            ST_RUN: begin
               work_q    <= '{a: rp_a2, b: rp_a1, c: work_q.a, d: work_q.b,
                              e: rp_e2, f: rp_e1, g: work_q.e, h: work_q.f};
               pre_h0_q  <= pre_h0_n;
               pre_dh0_q <= pre_dh0_n;
               pre_h1_q  <= pre_h1_n;
               pre_cg1_q <= pre_cg1_n;
               cnt_q     <= cnt_q + 1'b1;
               if (cnt_q == LAST) phase_q <= ST_FIN;
            end
            ST_FIN: begin
               digest_q <= ff_sum;
               done_q   <= 1'b1;
               phase_q  <= ST_IDLE;
            end
            default: phase_q <= ST_IDLE;
         endcase
      end
   end

   // monitors for the run-length and pair-count assertions
   logic [MON_W-1:0] mon_len_q;
   logic [MON_W-1:0] mon_take_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mon_len_q  <= '0;
         mon_take_q <= '0;
      end else begin
         if (accept)                mon_len_q <= '0;
         else if (phase_q != ST_IDLE) mon_len_q <= mon_len_q + 1'b1;
         if (accept)                mon_take_q <= MON_W'(1);
         else if (wk_take)          mon_take_q <= mon_take_q + 1'b1;
      end
   end

   AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (mon_len_q == MON_W'(PAIRS + 1)));                      // R3
   AST_PAIR_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (mon_take_q == MON_W'(PAIRS)));                         // R2
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                                 // R5
   AST_DIGEST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(digest) |-> done);                                      // R5
   AST_CHAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(chain_q));                                      // R6
   AST_BUSY_DURING_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !(phase_q == ST_FIN)) |=> busy);                        // R3
endmodule

// File: tb/sha2x_core_tb.sv
`timescale 1ns/1ps
module sha2x_core_tb;
   localparam logic [31:0] KT [0:63] = '{
      32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
      32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
      32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
      32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
      32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
      32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
      32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
      32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2};
   localparam logic [255:0] IV = {32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
                                  32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};
   localparam logic [255:0] DIG_ABC = 256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad;
   localparam logic [255:0] DIG_EMPTY = 256'he3b0c44298fc1c149afbf4c8996fb92427ae41e4649b934ca495991b7852b855;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [255:0] chain_in = '0;
   logic [31:0]  wk_lo = '0;
   logic [31:0]  wk_hi = '0;
   logic         wk_take, busy, done;
   logic [255:0] digest;

   int n_chk = 0;
   int n_bad = 0;
   logic [31:0] msg [16];
   logic [31:0] w_arr [64];
   logic [31:0] wk_arr [64];
   logic [255:0] dig_a, dig_b, ref_d;

   always #4 clk = ~clk;

   sha2x_core u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .chain_in(chain_in),
      .wk_lo(wk_lo), .wk_hi(wk_hi), .wk_take(wk_take), .busy(busy),
      .done(done), .digest(digest));

   function automatic logic [31:0] rr(input logic [31:0] x, input int n);
      return (x >> n) | (x << (32 - n));
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [255:0] act, input logic [255:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
      end
   endtask

   task automatic build_sched();
      for (int t = 0; t < 64; t++) begin
         if (t < 16) w_arr[t] = msg[t];
         else w_arr[t] = (rr(w_arr[t-2], 17) ^ rr(w_arr[t-2], 19) ^ (w_arr[t-2] >> 10))
                         + w_arr[t-7]
                         + (rr(w_arr[t-15], 7) ^ rr(w_arr[t-15], 18) ^ (w_arr[t-15] >> 3))
                         + w_arr[t-16];
         wk_arr[t] = w_arr[t] + KT[t];
      end
   endtask

   // behavioural reference: one round per loop step
   task automatic ref_compress(input logic [255:0] hin, output logic [255:0] hout);
      logic [31:0] v [8];
      logic [31:0] t1, t2;
      for (int i = 0; i < 8; i++) v[i] = hin[255-32*i -: 32];
      for (int t = 0; t < 64; t++) begin
         t1 = v[7] + (rr(v[4], 6) ^ rr(v[4], 11) ^ rr(v[4], 25))
              + ((v[4] & v[5]) ^ (~v[4] & v[6])) + KT[t] + w_arr[t];
         t2 = (rr(v[0], 2) ^ rr(v[0], 13) ^ rr(v[0], 22))
              + ((v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]));
         for (int i = 7; i > 0; i--) v[i] = v[i-1];
         v[4] = v[4] + t1;
         v[0] = t1 + t2;
      end
      for (int i = 0; i < 8; i++) hout[255-32*i -: 32] = hin[255-32*i -: 32] + v[i];
   endtask

   task automatic run_block(input logic [255:0] chain, input bit poke, output logic [255:0] got);
      build_sched();
      ref_compress(chain, ref_d);
      @(negedge clk);
      start = 1'b1; chain_in = chain; wk_lo = wk_arr[0]; wk_hi = wk_arr[1];
      #1;
      chk("R1", "busy before start edge", {255'd0, busy}, 256'd0);
      chk("R2", "wk_take on start", {255'd0, wk_take}, 256'd1);
      @(negedge clk);
      for (int n = 0; n <= 32; n++) begin
         if (n < 31) begin
            wk_lo = wk_arr[2*n+2]; wk_hi = wk_arr[2*n+3];
         end else begin
            wk_lo = 32'hdeadbeef; wk_hi = 32'h0badf00d;
         end
         if (poke && n == 10) begin start = 1'b1; chain_in = ~chain; end
         else begin start = 1'b0; chain_in = chain; end
         #1;
         chk(n == 0 ? "R1" : "R3", "busy in run", {255'd0, busy}, 256'd1);
         chk("R5", "done in run", {255'd0, done}, 256'd0);
         chk(poke && n == 10 ? "R6" : "R2", "wk_take in run",
             {255'd0, wk_take}, {255'd0, (n <= 30)});
         @(negedge clk);
      end
      start = 1'b0;
      #1;
      chk("R3", "busy after 33 cycles", {255'd0, busy}, 256'd0);
      chk("R5", "done pulse", {255'd0, done}, 256'd1);
      chk(poke ? "R6" : "R4", "digest vs model", digest, ref_d);
      got = digest;
      @(negedge clk);
      #1;
      chk("R5", "done falls", {255'd0, done}, 256'd0);
      chk("R5", "digest held", digest, got);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R7", "busy in reset", {255'd0, busy}, 256'd0);
      chk("R7", "done in reset", {255'd0, done}, 256'd0);
      chk("R7", "digest in reset", digest, 256'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R7", "wk_take idle", {255'd0, wk_take}, 256'd0);
      chk("R7", "busy after reset", {255'd0, busy}, 256'd0);

      // "abc"
      for (int i = 0; i < 16; i++) msg[i] = 32'h0;
      msg[0] = 32'h61626380; msg[15] = 32'h00000018;
      run_block(IV, 1'b0, dig_a);
      chk("R4", "abc known digest", dig_a, DIG_ABC);

      // empty message, with a start pulse mid-run
      for (int i = 0; i < 16; i++) msg[i] = 32'h0;
      msg[0] = 32'h80000000;
      run_block(IV, 1'b1, dig_b);
      chk("R6", "empty known digest despite start", dig_b, DIG_EMPTY);

      // continuation from a non-standard chaining value
      for (int i = 0; i < 16; i++) msg[i] = (32'h01010101 * (i + 1)) ^ 32'ha5a5c3c3;
      run_block(dig_a, 1'b0, dig_b);
      chk("R8", "continuation digest", dig_b, ref_d);

      // all-ones chaining, all-ones message
      for (int i = 0; i < 16; i++) msg[i] = 32'hffffffff;
      run_block({256{1'b1}}, 1'b0, dig_b);
      chk("R8", "all-ones digest", dig_b, ref_d);

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(8 * 200000);
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule